// File: doc/BRIEF.md
# Variable-Latency Operation Timing Tracker

This block tracks the timing of a floating-point execution cluster in which every operation class has its own latency and its own initiation interval. An issue request carries a class code and a destination tag. The block reports, per class, whether that class may start an operation in the current cycle. It accepts the request only when the selected class is ready. Once the class latency has passed, it raises a one-cycle completion pulse that carries the tag.

The block has one completion lane per class. Operations of the same class always complete in issue order and never share a cycle. Operations of different classes complete independently, so results can leave in a different order from issue. Several results can also appear in the same cycle without any being lost. No arithmetic is performed: only the busy and completion timing is modelled.

Top module: `fpt_timing_tracker`

## Requirements
- R1: After reset every class reports ready (`ready_o` all ones) and no completion lane is active.
- R2: Class codes are 0 add/subtract (latency 4, interval 3), 1 multiply (8, 4), 2 divide (36, 35), 3 square root (112, 111), 4 negate (2, 1), 5 absolute value (2, 1) and 6 compare (3, 2). An operation accepted in cycle c raises `done_o[class]` in cycle c+latency only, and `done_tag_o` lane `class` holds its tag in that cycle.
- R3: After a class accepts an issue in cycle c, `ready_o[class]` stays low until cycle c+interval, when it returns high.
- R4: A request to a class that is not ready is refused: `issue_ok_o` is low and the request never produces a completion.
- R5: Completions of different classes are independent, so a short operation issued after a long one completes first.
- R6: Completions of different classes that land in the same cycle are all reported, each on its own lane with its own tag.
- R7: A class issued at its full rate keeps all of its operations in flight, and they complete in consecutive intervals with their own tags.
- R8: Class code 7 is never accepted and produces no completion on any lane.
- R9: Asserting `rst_ni` low clears all interval counters and discards every operation in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| issue_valid_i | input | 1 | Issue request present |
| issue_cls_i | input | 3 | Class code of the request |
| issue_tag_i | input | TAG_W | Destination tag of the request |
| ready_o | output | 7 | Per-class ready flags |
| issue_ok_o | output | 1 | Request accepted this cycle |
| done_o | output | 7 | Per-class completion pulses |
| done_tag_o | output | 7*TAG_W | Per-lane completion tags, lane k at bits k*TAG_W upward |

## Verification
Two completions from different classes can fall in the same cycle, because their latencies differ and their issue times are offset. The bench provokes this by issuing a multiply and, four cycles later, an add/subtract, so both finish eight cycles after the multiply. It then requires both lanes to pulse in that one cycle with their own tags. A second overlap, where a completion and a new issue of the same class reuse one tracking slot in the same cycle, is provoked by issuing negate on every cycle, and each tag is checked on consecutive cycles.

// File: rtl/fpt_pkg.sv
package fpt_pkg;
  localparam int NUM_CLS = 7;
  localparam int CLS_W   = 3;

  typedef enum logic [CLS_W-1:0] {
    CLS_ADD  = 3'd0,
    CLS_MUL  = 3'd1,
    CLS_DIV  = 3'd2,
    CLS_SQRT = 3'd3,
    CLS_NEG  = 3'd4,
    CLS_ABS  = 3'd5,
    CLS_CMP  = 3'd6,
    CLS_NONE = 3'd7
  } op_cls_e;

  function automatic int cls_lat(int k);
    case (k)
      0: return 4;
      1: return 8;
      2: return 36;
      3: return 112;
      4: return 2;
      5: return 2;
      default: return 3;
    endcase
  endfunction

  function automatic int cls_ii(int k);
    case (k)
      0: return 3;
      1: return 4;
      2: return 35;
      3: return 111;
      4: return 1;
      5: return 1;
      default: return 2;
    endcase
  endfunction

  // slots needed to hold every op of one class at full issue rate
  function automatic int cls_depth(int k);
    return (cls_lat(k) + cls_ii(k) - 1) / cls_ii(k);
  endfunction
endpackage

// File: rtl/fpt_interval.sv
module fpt_interval #(
  parameter int II = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  output logic rdy_o
);
  localparam int CW = $clog2(II + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (fire_i)             cnt_q <= CW'(II - 1);
    else if (cnt_q != '0)        cnt_q <= cnt_q - 1'b1;
  end

  assign rdy_o = (cnt_q == '0);

  generate
    if (II > 1) begin : g_chk
      a_r3_busy_after_fire: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fire_i |=> !rdy_o);
    end
  endgenerate
endmodule

// File: rtl/fpt_flight.sv
module fpt_flight #(
  parameter int LAT   = 4,
  parameter int II    = 3,
  parameter int DEPTH = 2,
  parameter int TAG_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             issue_i,
  input  logic [TAG_W-1:0] tag_i,
  output logic             done_o,
  output logic [TAG_W-1:0] tag_o
);
  localparam int CW = $clog2(LAT + 1);

  logic [DEPTH-1:0]  vld_q;
  logic [CW-1:0]     cnt_q [DEPTH];
  logic [TAG_W-1:0]  tag_q [DEPTH];
  logic [DEPTH-1:0]  fin;
  logic [DEPTH-1:0]  free;
  logic [DEPTH-1:0]  grant;

  always_comb begin
    for (int s = 0; s < DEPTH; s++) begin
      fin[s]  = vld_q[s] && (cnt_q[s] == '0);
      free[s] = !vld_q[s] || fin[s];
    end
  end

  // lowest free slot; a finishing slot may be refilled in the same cycle
  always_comb begin
    logic taken;
    taken = 1'b0;
    grant = '0;
    for (int s = 0; s < DEPTH; s++) begin
      if (free[s] && !taken) begin
        grant[s] = 1'b1;
        taken    = 1'b1;
      end
    end
  end

  always_comb begin
    tag_o = '0;
    for (int s = 0; s < DEPTH; s++)
      if (fin[s]) tag_o = tag_o | tag_q[s];
  end

  assign done_o = |fin;

  generate
    for (genvar s = 0; s < DEPTH; s++) begin : g_slot
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          vld_q[s] <= 1'b0;
          cnt_q[s] <= '0;
          tag_q[s] <= '0;
        end else if (issue_i && grant[s]) begin
          vld_q[s] <= 1'b1;
          cnt_q[s] <= CW'(LAT - 1);
          tag_q[s] <= tag_i;
        end else if (fin[s]) begin
          vld_q[s] <= 1'b0;
        end else if (vld_q[s]) begin
          cnt_q[s] <= cnt_q[s] - 1'b1;
        end
      end
    end
  endgenerate

  a_r7_slot_available: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_i |-> (|free));

  a_r6_single_finisher: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(fin));

  generate
    if (II > 1) begin : g_gap
      a_r2_pulse_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);
    end
  endgenerate
endmodule

// File: rtl/fpt_timing_tracker.sv
module fpt_timing_tracker
  import fpt_pkg::*;
#(
  parameter int TAG_W = 5
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     issue_valid_i,
  input  logic [CLS_W-1:0]         issue_cls_i,
  input  logic [TAG_W-1:0]         issue_tag_i,
  output logic [NUM_CLS-1:0]       ready_o,
  output logic                     issue_ok_o,
  output logic [NUM_CLS-1:0]       done_o,
  output logic [NUM_CLS*TAG_W-1:0] done_tag_o
);
  localparam int CODES = 1 << CLS_W;

  logic [CODES-1:0]   rdy_ext;
  logic [NUM_CLS-1:0] fire;

  assign rdy_ext    = {{(CODES-NUM_CLS){1'b0}}, ready_o};
  assign issue_ok_o = issue_valid_i && rdy_ext[issue_cls_i];

  generate
    for (genvar k = 0; k < NUM_CLS; k++) begin : g_cls
      localparam int L = cls_lat(k);
      localparam int I = cls_ii(k);
      localparam int D = cls_depth(k);

      assign fire[k] = issue_ok_o && (issue_cls_i == CLS_W'(k));

      fpt_interval #(.II(I)) u_gap (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .fire_i (fire[k]),
        .rdy_o  (ready_o[k])
      );

      fpt_flight #(.LAT(L), .II(I), .DEPTH(D), .TAG_W(TAG_W)) u_fly (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .issue_i (fire[k]),
        .tag_i   (issue_tag_i),
        .done_o  (done_o[k]),
        .tag_o   (done_tag_o[k*TAG_W +: TAG_W])
      );
    end
  endgenerate

  a_r4_fire_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(fire));

  a_r8_none_never_fires: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_cls_i == CLS_NONE) |-> (fire == '0));
endmodule

// File: tb/sim_fpt_timing_tracker.sv
module sim_fpt_timing_tracker;
  localparam int TW = 5;
  localparam int NC = 7;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          issue_valid_i = 1'b0;
  logic [2:0]    issue_cls_i = '0;
  logic [TW-1:0] issue_tag_i = '0;
  logic [NC-1:0] ready_o;
  logic          issue_ok_o;
  logic [NC-1:0] done_o;
  logic [NC*TW-1:0] done_tag_o;

  int total = 0;
  int bad = 0;

  int lat_t [NC] = '{4, 8, 36, 112, 2, 2, 3};
  int ii_t  [NC] = '{3, 4, 35, 111, 1, 1, 2};

  fpt_timing_tracker #(.TAG_W(TW)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .issue_valid_i(issue_valid_i),
    .issue_cls_i(issue_cls_i), .issue_tag_i(issue_tag_i), .ready_o(ready_o),
    .issue_ok_o(issue_ok_o), .done_o(done_o), .done_tag_o(done_tag_o)
  );

  always #5 clk = ~clk;

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog act=%0d exp=%0d", 200000, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic int lane_tag(int k);
    return int'(done_tag_o[k*TW +: TW]);
  endfunction

  // called just after a rising edge; returns 1 ns after the issue edge
  task automatic issue(input int cls, input int tag, output bit ok);
    issue_valid_i = 1'b1;
    issue_cls_i   = 3'(cls);
    issue_tag_i   = TW'(tag);
    #1 ok = issue_ok_o;
    @(posedge clk);
    #1 issue_valid_i = 1'b0;
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic t_reset_state();
    chk(ready_o == 7'h7F, "R1 ready", int'(ready_o), 127);
    chk(done_o == '0, "R1 done", int'(done_o), 0);
  endtask

  task automatic t_latency_all();
    bit ok;
    for (int k = 0; k < NC; k++) begin
      issue(k, 10 + k, ok);
      chk(ok, "R2 accept", int'(ok), 1);
      repeat (lat_t[k] - 2) @(posedge clk);
      #1 chk(done_o[k] == 1'b0, "R2 early", int'(done_o[k]), 0);
      step();
      chk(done_o[k] == 1'b1, "R2 on time", int'(done_o[k]), 1);
      chk(lane_tag(k) == 10 + k, "R2 tag", lane_tag(k), 10 + k);
      step();
      chk(done_o[k] == 1'b0, "R2 pulse end", int'(done_o[k]), 0);
    end
  endtask

  task automatic t_interval();
    bit ok;
    issue(0, 3, ok);
    chk(ready_o[0] == 1'b0, "R3 busy c+1", int'(ready_o[0]), 0);
    step();
    chk(ready_o[0] == 1'b0, "R3 busy c+2", int'(ready_o[0]), 0);
    step();
    chk(ready_o[0] == 1'b1, "R3 ready c+3", int'(ready_o[0]), 1);
    repeat (5) step();
  endtask

  task automatic t_refused();
    bit ok;
    int cnt = 0;
    int last = 0;
    issue(0, 1, ok);
    issue(0, 2, ok);
    chk(!ok, "R4 refused", int'(ok), 0);
    for (int i = 0; i < 8; i++) begin
      if (done_o[0]) begin cnt++; last = lane_tag(0); end
      step();
    end
    chk(cnt == 1, "R4 one completion", cnt, 1);
    chk(last == 1, "R4 tag", last, 1);
  endtask

  task automatic t_out_of_order();
    bit ok;
    issue(2, 5, ok);
    issue(4, 6, ok);
    step();
    chk(done_o[4] == 1'b1 && lane_tag(4) == 6, "R5 short first", lane_tag(4), 6);
    chk(done_o[2] == 1'b0, "R5 long pending", int'(done_o[2]), 0);
    repeat (32) @(posedge clk);
    #1 chk(done_o[2] == 1'b0, "R5 long early", int'(done_o[2]), 0);
    step();
    chk(done_o[2] == 1'b1 && lane_tag(2) == 5, "R5 long done", lane_tag(2), 5);
    repeat (3) step();
  endtask

  task automatic t_same_cycle();
    bit ok;
    issue(1, 17, ok);
    repeat (3) @(posedge clk);
    #1 issue(0, 18, ok);
    repeat (3) @(posedge clk);
    #2;
    chk(done_o[1] == 1'b1 && done_o[0] == 1'b1, "R6 both lanes", int'(done_o[1:0]), 3);
    chk(lane_tag(1) == 17, "R6 mul tag", lane_tag(1), 17);
    chk(lane_tag(0) == 18, "R6 add tag", lane_tag(0), 18);
    repeat (3) step();
  endtask

  task automatic t_full_rate();
    bit ok;
    bit all_ok = 1'b1;
    issue(4, 20, ok); all_ok &= ok;
    issue(4, 21, ok); all_ok &= ok;
    chk(done_o[4] == 1'b1 && lane_tag(4) == 20, "R7 first", lane_tag(4), 20);
    issue(4, 22, ok); all_ok &= ok;
    chk(all_ok, "R7 accepted", int'(all_ok), 1);
    chk(done_o[4] == 1'b1 && lane_tag(4) == 21, "R7 second", lane_tag(4), 21);
    step();
    chk(done_o[4] == 1'b1 && lane_tag(4) == 22, "R7 third", lane_tag(4), 22);
    step();
    chk(done_o[4] == 1'b0, "R7 drained", int'(done_o[4]), 0);
  endtask

  task automatic t_bad_code();
    bit ok;
    int cnt = 0;
    issue(7, 9, ok);
    chk(!ok, "R8 refused", int'(ok), 0);
    for (int i = 0; i < 10; i++) begin
      if (done_o != '0) cnt++;
      step();
    end
    chk(cnt == 0, "R8 no completion", cnt, 0);
  endtask

  task automatic t_reset_flush();
    bit ok;
    int cnt = 0;
    issue(3, 9, ok);
    issue(1, 8, ok);
    repeat (5) step();
    rst_ni = 1'b0;
    #2;
    chk(ready_o == 7'h7F, "R9 ready cleared", int'(ready_o), 127);
    @(negedge clk) rst_ni = 1'b1;
    step();
    for (int i = 0; i < 120; i++) begin
      if (done_o != '0) cnt++;
      step();
    end
    chk(cnt == 0, "R9 flushed", cnt, 0);
  endtask

  initial begin
    #12 rst_ni = 1'b1;
    #1 t_reset_state();
    step();
    t_latency_all();
    t_interval();
    t_refused();
    t_out_of_order();
    t_same_cycle();
    t_full_rate();
    t_bad_code();
    t_reset_flush();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule